// File: doc/BRIEF.md
# Single-Channel Fly-By DMA Controller

The controller moves bytes between memory and one peripheral without the processor touching each byte. Software loads a start offset, a page, a byte count and a mode word through a small register-write port. The last write arms the channel. After that the peripheral's request line alone decides when bus traffic begins. The controller asks the processor for the bus and waits for the grant. It then raises an address-enable so that ordinary I/O decoders stay quiet, and runs fixed four-clock transfer cycles.

Each transfer cycle puts a memory address on the bus and selects the peripheral with its acknowledge line. No I/O port address is driven. The controller then pulses a memory strobe and an I/O strobe at the same time. The data therefore flows straight from the source to the destination, and nothing is held inside the controller. The upper address bits come from a fixed page value, so the 16-bit offset counter wraps inside its 64 KB page. Two modes are supported. Block mode runs to the end of the count once it has started. Demand mode gives the bus back whenever the peripheral withdraws its request, and continues when the request returns.

Top module: `dma_fly_ctrl`

## Requirements
- R1: While reset is low, and after reset with no traffic: hold, aen, all four strobes and tc are 0, addr is 0, and dack sits at its inactive level (0 after reset).
- R2: An armed channel does nothing until the request is at its active level. It then raises hold. aen is raised only after hlda has been seen high, and never in the same cycle that hold first rises.
- R3: Every byte takes exactly four clocks. The first clock drives the address and dack with no strobe. The second and third clocks assert the strobe pair. The fourth clock releases the strobes. Successive bytes of an uninterrupted run therefore start their strobes 4 clocks apart.
- R4: Mode bit 0 selects the direction. When it is 0 (memory to device), memr and iow are asserted together. When it is 1 (device to memory), ior and memw are asserted together. The other two strobes stay low.
- R5: During a transfer, addr is {page[7:0], offset[15:0]}. The offset rises by one per byte and wraps from 0xFFFF to 0x0000, and the page never changes. While aen is low, addr is 0.
- R6: The count field holds the number of bytes minus one. tc is high only together with the strobes of the final byte.
- R7: After the final byte, hold, aen and dack drop in the same clock. No further request or strobe appears, even with the request active, until the channel is armed again.
- R8: Mode bit 1 = 0 selects block mode: once the bus is granted, bytes follow back to back whether or not the request stays active.
- R9: Mode bit 1 = 1 selects demand mode: if the request is inactive at the end of a byte, hold, aen and dack are released. When the request returns, the channel asks for the bus again and continues with the next address and the remaining count.
- R10: Mode bit 2 = 1 makes the request pin active-low. Mode bit 3 = 1 makes the dack pin active-low, and its idle level becomes 1.
- R11: Register writes are ignored while the channel is armed or moving data.
- R12: Register select 0 loads the offset, 1 the page (low 8 bits), 2 the count and 3 the mode (bits 3:0). A mode write with bit 4 set arms the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 16 | Register write data |
| drq | input | 1 | Peripheral request, polarity set by mode |
| hlda | input | 1 | Bus grant from the processor |
| hold | output | 1 | Bus request to the processor |
| aen | output | 1 | Address enable, masks ordinary I/O decode |
| dack | output | 1 | Peripheral acknowledge, polarity set by mode |
| addr | output | 24 | Memory address {page, offset} |
| memr | output | 1 | Memory read strobe |
| memw | output | 1 | Memory write strobe |
| ior | output | 1 | I/O read strobe |
| iow | output | 1 | I/O write strobe |
| tc | output | 1 | Terminal count, final byte |

## Verification
A write to the mode register takes effect at the next edge. The channel is armed one clock later. hold follows the first clock that sees an active request, and aen comes one clock after the grant. Within a byte, the strobes are due on the second of its four clocks and tc rides with them. Consecutive bytes are checked for a strobe spacing of exactly four clocks. The bench samples on the falling edge, so it always sees settled register outputs. The scoreboard pops an expected byte at the rising edge of each strobe pair, and waits on hold rather than on a fixed delay whenever the grant latency is set by the bench's processor model.

// File: rtl/dma_fly_pkg.sv
package dma_fly_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_BUSREQ,
        ST_ADDR,
        ST_STRB,
        ST_KEEP,
        ST_REL
    } seq_state_e;

    localparam logic [1:0] SEL_OFS  = 2'd0;
    localparam logic [1:0] SEL_PAGE = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_MODE = 2'd3;

    localparam int MODE_DIR_BIT  = 0;
    localparam int MODE_DMD_BIT  = 1;
    localparam int MODE_RQLO_BIT = 2;
    localparam int MODE_AKLO_BIT = 3;
    localparam int MODE_ARM_BIT  = 4;

    typedef struct packed {
        logic io_to_mem;
        logic demand;
        logic req_low;
        logic ack_low;
    } mode_t;

endpackage

// File: rtl/dma_fly_regs.sv
module dma_fly_regs
    import dma_fly_pkg::*;
#(
    parameter int OFS_W  = 16,
    parameter int PAGE_W = 8,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [1:0]        sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              busy_i,
    output logic [OFS_W-1:0]  ofs_o,
    output logic [PAGE_W-1:0] page_o,
    output logic [CNT_W-1:0]  cnt_o,
    output mode_t             mode_o,
    output logic              start_o
);

    typedef struct packed {
        logic [OFS_W-1:0]  ofs;
        logic [PAGE_W-1:0] page;
        logic [CNT_W-1:0]  cnt;
        mode_t             mode;
        logic              start;
    } regs_t;

    regs_t reg_d, reg_q;

    always_comb begin
        reg_d       = reg_q;
        reg_d.start = 1'b0;
        if (we_i && !busy_i) begin
            case (sel_i)
                SEL_OFS:  reg_d.ofs  = wdata_i[OFS_W-1:0];
                SEL_PAGE: reg_d.page = wdata_i[PAGE_W-1:0];
                SEL_CNT:  reg_d.cnt  = wdata_i[CNT_W-1:0];
                default: begin
                    reg_d.mode.io_to_mem = wdata_i[MODE_DIR_BIT];
                    reg_d.mode.demand    = wdata_i[MODE_DMD_BIT];
                    reg_d.mode.req_low   = wdata_i[MODE_RQLO_BIT];
                    reg_d.mode.ack_low   = wdata_i[MODE_AKLO_BIT];
                    reg_d.start          = wdata_i[MODE_ARM_BIT];
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign ofs_o   = reg_q.ofs;
    assign page_o  = reg_q.page;
    assign cnt_o   = reg_q.cnt;
    assign mode_o  = reg_q.mode;
    assign start_o = reg_q.start;

    assert_no_write_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_i) |-> ($stable(reg_q.ofs) && $stable(reg_q.page) &&
                           $stable(reg_q.cnt) && $stable(reg_q.mode) && !reg_q.start));

endmodule

// File: rtl/dma_fly_pol.sv
module dma_fly_pol (
    input  logic req_pin_i,
    input  logic req_low_i,
    input  logic ack_act_i,
    input  logic ack_low_i,
    output logic req_act_o,
    output logic ack_pin_o
);

    assign req_act_o = req_pin_i ^ req_low_i;
    assign ack_pin_o = ack_act_i ^ ack_low_i;

endmodule

// File: rtl/dma_fly_seq.sv
module dma_fly_seq
    import dma_fly_pkg::*;
#(
    parameter int OFS_W  = 16,
    parameter int PAGE_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [OFS_W-1:0]        base_ofs_i,
    input  logic [CNT_W-1:0]        base_cnt_i,
    input  logic [PAGE_W-1:0]       page_i,
    input  logic                    io_to_mem_i,
    input  logic                    demand_i,
    input  logic                    req_act_i,
    input  logic                    hlda_i,
    output logic                    hold_o,
    output logic                    aen_o,
    output logic                    ack_act_o,
    output logic [PAGE_W+OFS_W-1:0] addr_o,
    output logic                    memr_o,
    output logic                    memw_o,
    output logic                    ior_o,
    output logic                    iow_o,
    output logic                    tc_o,
    output logic                    busy_o
);

    localparam int                ADDR_W  = PAGE_W + OFS_W;
    localparam logic [OFS_W-1:0]  OFS_ONE = OFS_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);

    typedef struct packed {
        seq_state_e       state;
        logic [OFS_W-1:0] ofs;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    logic in_cycle;
    logic strobe;
    logic last_byte;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.state = ST_ARMED;
                    seq_d.ofs   = base_ofs_i;
                    seq_d.cnt   = base_cnt_i;
                end
            end
            ST_ARMED:  if (req_act_i) seq_d.state = ST_BUSREQ;
            ST_BUSREQ: if (hlda_i)    seq_d.state = ST_ADDR;
            ST_ADDR:   seq_d.state = ST_STRB;
            ST_STRB:   seq_d.state = ST_KEEP;
            ST_KEEP:   seq_d.state = ST_REL;
            ST_REL: begin
                seq_d.ofs = seq_q.ofs + OFS_ONE;
                seq_d.cnt = seq_q.cnt - CNT_ONE;
                if (last_byte)                    seq_d.state = ST_IDLE;
                else if (!demand_i || req_act_i)  seq_d.state = ST_ADDR;
                else                              seq_d.state = ST_ARMED;
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{state: ST_IDLE, ofs: '0, cnt: '0};
        else        seq_q <= seq_d;
    end

    assign last_byte = (seq_q.cnt == '0);
    assign in_cycle  = (seq_q.state == ST_ADDR) || (seq_q.state == ST_STRB) ||
                       (seq_q.state == ST_KEEP) || (seq_q.state == ST_REL);
    assign strobe    = (seq_q.state == ST_STRB) || (seq_q.state == ST_KEEP);

    assign hold_o    = in_cycle || (seq_q.state == ST_BUSREQ);
    assign aen_o     = in_cycle;
    assign ack_act_o = in_cycle;
    assign addr_o    = in_cycle ? {page_i, seq_q.ofs} : ADDR_W'(0);
    assign memr_o    = strobe && !io_to_mem_i;
    assign iow_o     = strobe && !io_to_mem_i;
    assign ior_o     = strobe &&  io_to_mem_i;
    assign memw_o    = strobe &&  io_to_mem_i;
    assign tc_o      = strobe && last_byte;
    assign busy_o    = (seq_q.state != ST_IDLE);

    assert_aen_after_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aen_o) |-> ($past(hlda_i) && $past(hold_o)));

    assert_hold_on_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> $past(req_act_i));

    assert_strobe_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (memr_o || memw_o || ior_o || iow_o) |->
            ((memr_o == iow_o) && (ior_o == memw_o) && (memr_o != ior_o) && aen_o));

    assert_strobe_two_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(memr_o || ior_o) |=> (memr_o || ior_o));

    assert_strobe_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((memr_o || ior_o) && $past(memr_o || ior_o)) |=> !(memr_o || ior_o));

    assert_tc_with_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |-> (memr_o || ior_o));

    assert_release_together_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(aen_o) |-> (!hold_o && !ack_act_o));

    assert_page_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (aen_o && $past(aen_o)) |-> $stable(addr_o[ADDR_W-1:OFS_W]));

endmodule

// File: rtl/dma_fly_ctrl.sv
module dma_fly_ctrl
    import dma_fly_pkg::*;
#(
    parameter int OFS_W  = 16,
    parameter int PAGE_W = 8,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_sel,
    input  logic [DATA_W-1:0]       cfg_wdata,
    input  logic                    drq,
    input  logic                    hlda,
    output logic                    hold,
    output logic                    aen,
    output logic                    dack,
    output logic [PAGE_W+OFS_W-1:0] addr,
    output logic                    memr,
    output logic                    memw,
    output logic                    ior,
    output logic                    iow,
    output logic                    tc
);

    logic [OFS_W-1:0]  base_ofs;
    logic [PAGE_W-1:0] page;
    logic [CNT_W-1:0]  base_cnt;
    mode_t             mode;
    logic              start;
    logic              busy;
    logic              req_act;
    logic              ack_act;

    dma_fly_regs #(
        .OFS_W (OFS_W),
        .PAGE_W(PAGE_W),
        .CNT_W (CNT_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (cfg_we),
        .sel_i  (cfg_sel),
        .wdata_i(cfg_wdata),
        .busy_i (busy),
        .ofs_o  (base_ofs),
        .page_o (page),
        .cnt_o  (base_cnt),
        .mode_o (mode),
        .start_o(start)
    );

    dma_fly_pol u_pol (
        .req_pin_i(drq),
        .req_low_i(mode.req_low),
        .ack_act_i(ack_act),
        .ack_low_i(mode.ack_low),
        .req_act_o(req_act),
        .ack_pin_o(dack)
    );

    dma_fly_seq #(
        .OFS_W (OFS_W),
        .PAGE_W(PAGE_W),
        .CNT_W (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .base_ofs_i (base_ofs),
        .base_cnt_i (base_cnt),
        .page_i     (page),
        .io_to_mem_i(mode.io_to_mem),
        .demand_i   (mode.demand),
        .req_act_i  (req_act),
        .hlda_i     (hlda),
        .hold_o     (hold),
        .aen_o      (aen),
        .ack_act_o  (ack_act),
        .addr_o     (addr),
        .memr_o     (memr),
        .memw_o     (memw),
        .ior_o      (ior),
        .iow_o      (iow),
        .tc_o       (tc),
        .busy_o     (busy)
    );

endmodule

// File: tb/dma_fly_ctrl_bench.sv
module dma_fly_ctrl_bench;

    typedef struct packed {
        logic [23:0] addr;
        logic        io2mem;
        logic        tc;
        logic        ack_low;
        logic        chk_gap;
    } xfer_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        drq = 1'b0;
    logic        hlda = 1'b0;
    logic        hold, aen, dack, memr, memw, ior, iow, tc;
    logic [23:0] addr;

    xfer_t exp_q[$];
    int vectors = 0;
    int errs = 0;
    int n_seen = 0;
    int cyc = 0;
    int last_rise = 0;
    logic prev_strb = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dma_fly_ctrl u_dma_fly_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .drq(drq), .hlda(hlda), .hold(hold),
        .aen(aen), .dack(dack), .addr(addr), .memr(memr), .memw(memw),
        .ior(ior), .iow(iow), .tc(tc)
    );

    // processor model: grant follows request one clock later
    always @(posedge clk) begin
        hlda <= hold & rst_n;
        cyc  <= cyc + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [23:0] a, input logic dir, input logic last,
                        input logic al, input logic gap);
        xfer_t it;
        it.addr = a; it.io2mem = dir; it.tc = last; it.ack_low = al; it.chk_gap = gap;
        exp_q.push_back(it);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        bit ok = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !hold) begin
                ok = 1'b1;
                break;
            end
        end
        chk({tag, " run completes"}, {31'd0, ok}, 32'd1);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic strb;
            strb = memr | ior;
            if (tc && !strb) chk("R6 tc without strobe", 32'd1, 32'd0);
            if (strb && !prev_strb) begin
                n_seen++;
                if (exp_q.size() == 0) begin
                    chk("R7 unexpected transfer", 32'd1, 32'd0);
                end else begin
                    xfer_t it;
                    it = exp_q.pop_front();
                    chk("R5 address", {8'd0, addr}, {8'd0, it.addr});
                    chk("R4 strobe pair", {28'd0, memr, iow, ior, memw},
                        {28'd0, ~it.io2mem, ~it.io2mem, it.io2mem, it.io2mem});
                    chk("R6 terminal count", {31'd0, tc}, {31'd0, it.tc});
                    chk("R10 dack level", {31'd0, dack}, {31'd0, ~it.ack_low});
                    chk("R2 aen during transfer", {31'd0, aen & hold}, 32'd1);
                    if (it.chk_gap) chk("R3 four-clock spacing", cyc - last_rise, 32'd4);
                end
                last_rise = cyc;
            end
            prev_strb = strb;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        int n0;
        bit hseen;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs", {25'd0, hold, aen, dack, memr, memw, ior, iow}, 32'd0);
        chk("R1 reset addr/tc", {7'd0, tc, addr}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", {28'd0, hold, aen, dack, tc}, 32'd0);

        // A: block, memory to device, 4 bytes (R4 R6 R8 R12)
        wr(2'd0, 16'h0010);
        wr(2'd1, 16'h0012);
        wr(2'd2, 16'd3);
        push(24'h120010, 1'b0, 1'b0, 1'b0, 1'b0);
        push(24'h120011, 1'b0, 1'b0, 1'b0, 1'b1);
        push(24'h120012, 1'b0, 1'b0, 1'b0, 1'b1);
        push(24'h120013, 1'b0, 1'b1, 1'b0, 1'b1);
        wr(2'd3, 16'h0010);
        repeat (5) @(negedge clk);
        chk("R2 no request without drq", {31'd0, hold}, 32'd0);
        drq = 1'b1;
        hseen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (hold) begin hseen = 1'b1; break; end
        end
        chk("R2 hold raised on drq", {31'd0, hseen}, 32'd1);
        chk("R2 aen waits for grant", {31'd0, aen}, 32'd0);
        drq = 1'b0;   // R8: block mode ignores the request once running
        wait_done("R8 block");
        chk("R7 release together", {29'd0, hold, aen, dack}, 32'd0);
        drq = 1'b1;
        hseen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (hold) hseen = 1'b1;
        end
        chk("R7 stays idle until rearmed", {31'd0, hseen}, 32'd0);
        drq = 1'b0;

        // B: offset wrap, device to memory (R5 R4)
        wr(2'd0, 16'hFFFE);
        wr(2'd1, 16'h0005);
        wr(2'd2, 16'd3);
        push(24'h05FFFE, 1'b1, 1'b0, 1'b0, 1'b0);
        push(24'h05FFFF, 1'b1, 1'b0, 1'b0, 1'b1);
        push(24'h050000, 1'b1, 1'b0, 1'b0, 1'b1);
        push(24'h050001, 1'b1, 1'b1, 1'b0, 1'b1);
        wr(2'd3, 16'h0011);
        drq = 1'b1;
        wait_done("R5 wrap");
        drq = 1'b0;

        // C: demand mode pause and resume, writes ignored while busy (R9 R11)
        wr(2'd0, 16'h0200);
        wr(2'd1, 16'h0033);
        wr(2'd2, 16'd4);
        push(24'h330200, 1'b0, 1'b0, 1'b0, 1'b0);
        push(24'h330201, 1'b0, 1'b0, 1'b0, 1'b1);
        push(24'h330202, 1'b0, 1'b0, 1'b0, 1'b0);
        push(24'h330203, 1'b0, 1'b0, 1'b0, 1'b1);
        push(24'h330204, 1'b0, 1'b1, 1'b0, 1'b1);
        n0 = n_seen;
        wr(2'd3, 16'h0012);
        drq = 1'b1;
        wait (n_seen == n0 + 2);
        @(negedge clk);
        drq = 1'b0;
        repeat (12) @(negedge clk);
        chk("R9 bus released in pause", {30'd0, hold, aen}, 32'd0);
        chk("R5 addr zero without aen", {8'd0, addr}, 32'd0);
        chk("R9 two bytes before pause", n_seen - n0, 32'd2);
        wr(2'd0, 16'h9999);
        wr(2'd2, 16'd0);
        wr(2'd3, 16'h001C);
        repeat (3) @(negedge clk);
        chk("R11 no restart from ignored write", {31'd0, hold}, 32'd0);
        drq = 1'b1;
        wait_done("R9 demand resume");
        chk("R11 byte total unchanged", n_seen - n0, 32'd5);
        drq = 1'b0;

        // D: active-low request and acknowledge (R10)
        drq = 1'b1;
        wr(2'd0, 16'h0040);
        wr(2'd1, 16'h007E);
        wr(2'd2, 16'd1);
        push(24'h7E0040, 1'b0, 1'b0, 1'b1, 1'b0);
        push(24'h7E0041, 1'b0, 1'b1, 1'b1, 1'b1);
        wr(2'd3, 16'h001C);
        repeat (4) @(negedge clk);
        chk("R10 dack idles high", {31'd0, dack}, 32'd1);
        chk("R10 high drq pin is inactive", {31'd0, hold}, 32'd0);
        drq = 1'b0;
        wait_done("R10 low polarity");
        chk("R10 dack back to idle", {31'd0, dack}, 32'd1);
        drq = 1'b1;

        repeat (4) @(negedge clk);
        done = 1'b1;
        chk("R7 no leftover expected bytes", exp_q.size(), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule